// File: doc/BRIEF.md
# Power-State-Qualified Cycle Counter Bank

This block holds three 40-bit clock-cycle counters for a core that runs two hardware threads. The *run counter* counts cycles in which at least one selected thread is running. A thread is running when it is not halted and the core is neither asleep nor in deep sleep. The *awake counter* counts cycles in which the core is neither asleep nor in deep sleep. The *timebase* counts every cycle except those spent in deep sleep.

Each of the two programmable counters has a four-bit qualification mask. The mask selects thread/privilege combinations. It also has an enable bit, and it can raise a maskable, sticky overflow interrupt for sampling.

Software reaches every counter and control word through a small register port. Writes take effect at the clock edge. Read data is combinational from the address.

Every counter wraps to zero. A write to a counter wins over an increment in the same cycle. The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `pwr_cycle_counters`

## Requirements
- R1: While reset is held, every register reads zero and `irq` is low.
- R2: The run counter (offset 0 = bits 31:0, offset 1 = bits 39:32) increments by one per cycle when all of the following hold: its control word (offset 6) has the enable bit 4 set, `core_sleep` and `deep_sleep` are low, and some thread t is not halted and has its mask bit set. The mask bits are: bit0 = thread0 supervisor, bit1 = thread0 user, bit2 = thread1 supervisor, bit3 = thread1 user. A thread's privilege is user when `thr_user[t]` is 1.
- R3: A halted thread never contributes to the run counter, even when its mask bits are set. Each thread is qualified separately, and only the mask bit matching the thread's current privilege counts.
- R4: The awake counter (offsets 2/3, control word at offset 7 with the same layout) increments when it is enabled, no sleep input is high, and any thread's privilege matches a set mask bit, whether or not that thread is halted.
- R5: The timebase (offsets 4/5) increments on every cycle in which `deep_sleep` is low, including cycles with `core_sleep` high. It holds while `deep_sleep` is high.
- R6: A programmable counter whose enable bit is clear holds its value.
- R7: Every counter wraps from all ones to zero. A wrap of the run counter sets status bit 0 (offset 8), and a wrap of the awake counter sets status bit 1. A timebase wrap sets no status bit.
- R8: Status bits stay set until a write to offset 8 with a 1 in that bit position. Writing 0 leaves them set. `irq` is the OR of the status bits that are masked in by the interrupt-enable word (offset 9, same bit positions).
- R9: A register write to a counter word in the same cycle as an increment loads the written value, and the increment is lost.
- R10: The control words, the interrupt-enable word and the counter high bytes read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_halted | input | 2 | Per-thread halted flag |
| thr_user | input | 2 | Per-thread privilege, 1 = user, 0 = supervisor |
| core_sleep | input | 1 | Core in sleep or a power-saving state |
| deep_sleep | input | 1 | Core in deep sleep |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that the power and thread inputs, and the register port, are stable and meaningful at every rising edge. They also assume that a write to one counter word never lands on another counter. The hold and step properties are therefore qualified by the absence of a write to the counter under check.

The bench changes inputs only one time unit after a rising edge and reads only in that quiet window. Before each measurement it zeroes a counter and keeps it disabled, so that only the planned number of edges can add to it.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_RUN_LO  = 4'd0;
  localparam logic [ADDR_W-1:0] A_RUN_HI  = 4'd1;
  localparam logic [ADDR_W-1:0] A_AWK_LO  = 4'd2;
  localparam logic [ADDR_W-1:0] A_AWK_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_TB_LO   = 4'd4;
  localparam logic [ADDR_W-1:0] A_TB_HI   = 4'd5;
  localparam logic [ADDR_W-1:0] A_RUN_CTL = 4'd6;
  localparam logic [ADDR_W-1:0] A_AWK_CTL = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd8;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd9;

  localparam int unsigned N_PROG = 2;  // 0 = run counter, 1 = awake counter

  function automatic logic [ADDR_W-1:0] lo_addr(input int unsigned idx);
    return ADDR_W'(2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] ctl_addr(input int unsigned idx);
    return ADDR_W'(6 + idx);
  endfunction
endpackage

// File: rtl/pcc_qual.sv
module pcc_qual #(
  parameter int unsigned NTHR = 2,
  parameter bit          NEED_RUN = 1'b1,
  localparam int unsigned MASK_W = 2 * NTHR
) (
  input  logic [NTHR-1:0]   halted,
  input  logic [NTHR-1:0]   user,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  logic [NTHR-1:0] thr_hit;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic priv_ok;
    assign priv_ok = user[t] ? mask[2*t+1] : mask[2*t];
    if (NEED_RUN) begin : g_run
      assign thr_hit[t] = priv_ok & ~halted[t];
    end else begin : g_any
      logic unused_halt;
      assign unused_halt = halted[t];
      assign thr_hit[t]  = priv_ok;
    end
  end

  assign hit = |thr_hit;
endmodule

// File: rtl/pcc_cnt.sv
module pcc_cnt #(
  parameter int unsigned W  = 40,
  parameter int unsigned DW = 32,
  localparam int unsigned HW = W - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  cnt,
  output logic          wrap
);
  logic [W-1:0] cnt_nxt;
  logic         cnt_ce;

  always_comb begin
    cnt_nxt = cnt;
    wrap    = 1'b0;
    if (we_lo) begin
      cnt_nxt = {cnt[W-1:DW], wdata};
    end else if (we_hi) begin
      cnt_nxt = {wdata[HW-1:0], cnt[DW-1:0]};
    end else if (inc) begin
      cnt_nxt = cnt + 1'b1;
      wrap    = &cnt;
    end
  end

  assign cnt_ce = we_lo | we_hi | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_ce) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pcc_stat.sv
module pcc_stat #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] status
);
  logic [N-1:0] status_nxt;
  logic         status_ce;

  always_comb begin
    status_nxt = status;
    if (clr_we) status_nxt = status_nxt & ~clr_bits;
    status_nxt = status_nxt | set;
  end

  assign status_ce = clr_we | (|set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (status_ce) begin
      status <= status_nxt;
    end
  end
endmodule

// File: rtl/pwr_cycle_counters.sv
module pwr_cycle_counters
  import pcc_pkg::*;
#(
  parameter int unsigned NTHR  = 2,
  parameter int unsigned CNT_W = 40,
  parameter int unsigned DW    = 32,
  localparam int unsigned MASK_W = 2 * NTHR,
  localparam int unsigned CTL_W  = MASK_W + 1,
  localparam int unsigned HW     = CNT_W - DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTHR-1:0]   thr_halted,
  input  logic [NTHR-1:0]   thr_user,
  input  logic              core_sleep,
  input  logic              deep_sleep,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic awake;
  assign awake = ~core_sleep & ~deep_sleep;

  // programmable counters
  logic [CTL_W-1:0]  ctl_q   [N_PROG];
  logic [CNT_W-1:0]  prog_cnt[N_PROG];
  logic [N_PROG-1:0] prog_wrap;

  for (genvar p = 0; p < N_PROG; p++) begin : g_prog
    logic qual_hit;
    logic ctl_we;
    logic cnt_inc;

    pcc_qual #(.NTHR(NTHR), .NEED_RUN(p == 0)) u_qual (
      .halted (thr_halted),
      .user   (thr_user),
      .mask   (ctl_q[p][MASK_W-1:0]),
      .hit    (qual_hit)
    );

    assign ctl_we  = reg_we && (reg_addr == ctl_addr(p));
    assign cnt_inc = ctl_q[p][MASK_W] & awake & qual_hit;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        ctl_q[p] <= '0;
      end else if (ctl_we) begin
        ctl_q[p] <= reg_wdata[CTL_W-1:0];
      end
    end

    pcc_cnt #(.W(CNT_W), .DW(DW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (cnt_inc),
      .we_lo (reg_we && (reg_addr == lo_addr(p))),
      .we_hi (reg_we && (reg_addr == lo_addr(p) + 1'b1)),
      .wdata (reg_wdata),
      .cnt   (prog_cnt[p]),
      .wrap  (prog_wrap[p])
    );
  end

  // timebase
  logic [CNT_W-1:0] tb_cnt;
  logic             tb_wrap;

  pcc_cnt #(.W(CNT_W), .DW(DW)) u_tb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (~deep_sleep),
    .we_lo (reg_we && (reg_addr == A_TB_LO)),
    .we_hi (reg_we && (reg_addr == A_TB_HI)),
    .wdata (reg_wdata),
    .cnt   (tb_cnt),
    .wrap  (tb_wrap)
  );

  // overflow status and interrupt enable
  logic [N_PROG-1:0] status;
  logic [N_PROG-1:0] ien_q;
  logic              ien_we;

  pcc_stat #(.N(N_PROG)) u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set      (prog_wrap),
    .clr_we   (reg_we && (reg_addr == A_STAT)),
    .clr_bits (reg_wdata[N_PROG-1:0]),
    .status   (status)
  );

  assign ien_we = reg_we && (reg_addr == A_IEN);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= reg_wdata[N_PROG-1:0];
    end
  end

  assign irq = |(status & ien_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RUN_LO:  reg_rdata = prog_cnt[0][DW-1:0];
      A_RUN_HI:  reg_rdata = DW'(prog_cnt[0][CNT_W-1:DW]);
      A_AWK_LO:  reg_rdata = prog_cnt[1][DW-1:0];
      A_AWK_HI:  reg_rdata = DW'(prog_cnt[1][CNT_W-1:DW]);
      A_TB_LO:   reg_rdata = tb_cnt[DW-1:0];
      A_TB_HI:   reg_rdata = DW'(tb_cnt[CNT_W-1:DW]);
      A_RUN_CTL: reg_rdata = DW'(ctl_q[0]);
      A_AWK_CTL: reg_rdata = DW'(ctl_q[1]);
      A_STAT:    reg_rdata = DW'(status);
      A_IEN:     reg_rdata = DW'(ien_q);
      default:   reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = tb_wrap ^ (^reg_wdata[DW-1:CTL_W]);

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;
endmodule

// File: rtl/pwr_cycle_counters_chk.sv
module pwr_cycle_counters_chk #(
  parameter int unsigned W  = 40,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          core_sleep,
  input logic          deep_sleep,
  input logic [W-1:0]  run_cnt,
  input logic [W-1:0]  awk_cnt,
  input logic [W-1:0]  tb_cnt,
  input logic          run_en,
  input logic [1:0]    status,
  input logic [1:0]    ien,
  input logic          irq
);
  logic wr_run, wr_awk, wr_tb, wr_stat;
  assign wr_run  = reg_we && (reg_addr == 4'd0 || reg_addr == 4'd1);
  assign wr_awk  = reg_we && (reg_addr == 4'd2 || reg_addr == 4'd3);
  assign wr_tb   = reg_we && (reg_addr == 4'd4 || reg_addr == 4'd5);
  assign wr_stat = reg_we && (reg_addr == 4'd8);

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep_sleep && !wr_tb) |=> (tb_cnt == $past(tb_cnt) + 1'b1)); // R5
  AST_TB_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_sleep && !wr_tb) |=> $stable(tb_cnt)); // R5
  AST_AWK_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_sleep || deep_sleep) && !wr_awk) |=> $stable(awk_cnt)); // R4
  AST_RUN_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_sleep || deep_sleep) && !wr_run) |=> $stable(run_cnt)); // R2
  AST_RUN_DIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_run) |=> $stable(run_cnt)); // R6
  AST_RUN_WRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> ($past(run_cnt) == {W{1'b1}})); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(wr_stat && reg_wdata[0])) |=> status[0]); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq); // R8
  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd0) |=> (run_cnt[DW-1:0] == $past(reg_wdata))); // R9
endmodule

bind pwr_cycle_counters pwr_cycle_counters_chk #(.W(CNT_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .core_sleep (core_sleep),
  .deep_sleep (deep_sleep),
  .run_cnt    (prog_cnt[0]),
  .awk_cnt    (prog_cnt[1]),
  .tb_cnt     (tb_cnt),
  .run_en     (ctl_q[0][MASK_W]),
  .status     (status),
  .ien        (ien_q),
  .irq        (irq)
);

// File: tb/tb_pwr_cycle_counters.sv
module tb_pwr_cycle_counters;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  thr_halted;
  logic [1:0]  thr_user;
  logic        core_sleep;
  logic        deep_sleep;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwr_cycle_counters dut (
    .clk(clk), .rst_n(rst_n), .thr_halted(thr_halted), .thr_user(thr_user),
    .core_sleep(core_sleep), .deep_sleep(deep_sleep), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all helpers start and end 1 time unit after a rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_in(input logic [1:0] h, input logic [1:0] u,
                        input logic sl, input logic dp);
    thr_halted = h; thr_user = u; core_sleep = sl; deep_sleep = dp;
  endtask

  // zero a programmable counter, apply inputs, enable, count n edges
  task automatic measure(input string req, input int sel, input logic [4:0] ctl,
                         input logic [1:0] h, input logic [1:0] u,
                         input logic sl, input logic dp, input int n,
                         input int exp);
    logic [31:0] v;
    logic [3:0]  ca, la;
    ca = sel ? 4'd7 : 4'd6;
    la = sel ? 4'd2 : 4'd0;
    wr(ca, 32'h0);
    wr(la, 32'h0);
    wr(la + 4'd1, 32'h0);
    set_in(h, u, sl, dp);
    wr(ca, {27'h0, ctl});
    run(n);
    rd(la, v);
    chk(req, v, exp);
    wr(ca, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk("R1 register zero in reset", v, 32'h0);
    end
    chk("R1 irq low in reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_run;
    measure("R2 t0 supervisor", 0, 5'h11, 2'b00, 2'b00, 0, 0, 7, 7);
    measure("R2 t0 user", 0, 5'h12, 2'b00, 2'b01, 0, 0, 5, 5);
    measure("R2 core_sleep gates", 0, 5'h1F, 2'b00, 2'b00, 1, 0, 6, 0);
    measure("R2 deep_sleep gates", 0, 5'h1F, 2'b00, 2'b00, 0, 1, 6, 0);
  endtask

  task automatic t_thread;
    measure("R3 halted thread ignored", 0, 5'h11, 2'b01, 2'b00, 0, 0, 6, 0);
    measure("R3 other thread counts", 0, 5'h14, 2'b01, 2'b00, 0, 0, 6, 6);
    measure("R3 privilege mismatch", 0, 5'h14, 2'b00, 2'b10, 0, 0, 6, 0);
  endtask

  task automatic t_awake;
    measure("R4 halted threads still count", 1, 5'h1F, 2'b11, 2'b00, 0, 0, 8, 8);
    measure("R4 core_sleep gates", 1, 5'h1F, 2'b00, 2'b00, 1, 0, 8, 0);
    measure("R4 deep_sleep gates", 1, 5'h1F, 2'b00, 2'b00, 0, 1, 8, 0);
    measure("R4 no mask match", 1, 5'h10, 2'b00, 2'b00, 0, 0, 8, 0);
  endtask

  task automatic t_enable;
    measure("R6 enable clear holds", 0, 5'h0F, 2'b00, 2'b00, 0, 0, 9, 0);
    measure("R6 awake enable clear holds", 1, 5'h0F, 2'b00, 2'b00, 0, 0, 9, 0);
  endtask

  task automatic t_timebase;
    logic [31:0] v0, v1;
    set_in(2'b00, 2'b00, 1, 0);
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h0);
    run(9);
    rd(4'd4, v0);
    chk("R5 timebase counts in core_sleep", v0, 32'd9);
    deep_sleep = 1'b1;
    run(4);
    rd(4'd4, v1);
    chk("R5 timebase holds in deep_sleep", v1, 32'd9);
    set_in(2'b00, 2'b00, 0, 0);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    set_in(2'b00, 2'b00, 0, 0);
    wr(4'd6, 32'h11);
    run(2);
    wr(4'd0, 32'd100);
    rd(4'd0, v);
    chk("R9 write beats increment", v, 32'd100);
    run(3);
    rd(4'd0, v);
    chk("R9 counting resumes", v, 32'd103);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(4'd6, 32'h0F);
    rd(4'd6, v);
    chk("R10 run control", v, 32'h0F);
    wr(4'd7, 32'h0A);
    rd(4'd7, v);
    chk("R10 awake control", v, 32'h0A);
    wr(4'd9, 32'h2);
    rd(4'd9, v);
    chk("R10 interrupt enable", v, 32'h2);
    wr(4'd1, 32'hAB);
    rd(4'd1, v);
    chk("R10 run high byte", v, 32'hAB);
    wr(4'd6, 32'h0);
    wr(4'd7, 32'h0);
    wr(4'd9, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    set_in(2'b00, 2'b00, 0, 0);
    wr(4'd6, 32'h0);
    wr(4'd0, 32'hFFFF_FFFE);
    wr(4'd1, 32'hFF);
    wr(4'd8, 32'h3);
    wr(4'd9, 32'h1);
    wr(4'd6, 32'h11);
    run(1);
    rd(4'd0, v);
    chk("R7 one below wrap", v, 32'hFFFF_FFFF);
    chk("R8 no irq before wrap", {31'h0, irq}, 32'h0);
    run(1);
    rd(4'd0, v);
    chk("R7 wrap low word", v, 32'h0);
    rd(4'd1, v);
    chk("R7 wrap high byte", v, 32'h0);
    rd(4'd8, v);
    chk("R7 status bit0 set", v, 32'h1);
    chk("R8 irq raised", {31'h0, irq}, 32'h1);
    wr(4'd8, 32'h0);
    rd(4'd8, v);
    chk("R8 write 0 keeps status", v, 32'h1);
    wr(4'd9, 32'h0);
    chk("R8 irq masked", {31'h0, irq}, 32'h0);
    wr(4'd9, 32'h1);
    chk("R8 irq unmasked", {31'h0, irq}, 32'h1);
    wr(4'd8, 32'h1);
    rd(4'd8, v);
    chk("R8 write 1 clears", v, 32'h0);
    chk("R8 irq drops", {31'h0, irq}, 32'h0);
    wr(4'd6, 32'h0);
    // timebase wrap sets nothing
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFF);
    run(1);
    rd(4'd4, v);
    chk("R7 timebase wraps", v, 32'h0);
    rd(4'd8, v);
    chk("R7 timebase wrap no status", v, 32'h0);
    wr(4'd9, 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_in(2'b00, 2'b00, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    run(4);
    t_run();
    t_thread();
    t_awake();
    t_enable();
    t_timebase();
    t_prio();
    t_readback();
    t_overflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule